// File: doc/BRIEF.md
# MD5 Message Padding Unit

This block sits in front of an MD5 compression core and turns a raw byte stream into the padded message that the core consumes. Bytes arrive one per transfer on a valid/ready input. The final byte of each message carries a last flag. The unit packs the bytes into 32-bit words and appends the padding itself: a 0x80 byte, zero bytes, and the 64-bit message length in bits. The result always fills a whole number of 512-bit blocks.

Words leave on a valid/ready output. Three strobes travel with each word. One marks the sixteenth word of every block. One marks every word of a message's first block. One marks the closing word of the message's last block. With these the core knows when to load its starting chaining value and when the digest is complete.

The unit advances one byte position per cycle. Backpressure at the output stalls the byte sequencer and, through it, the input. Messages follow one another with no gap, and each one has its own length count.

Top module: `md5_pad_unit`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a message, `out_valid` is 0 and `in_ready` is 1. No partial message survives the reset.
- R2: Message byte i appears in output word i/4 at bits [8*(i%4)+7 : 8*(i%4)]. The first byte of a message sits in bits 7:0 of its first word.
- R3: The byte after the last message byte is 0x80. Every byte after it is 0x00 up to byte offset 55 of the block that holds the length.
- R4: Byte offsets 56 to 63 of a message's last block hold the message length in bits, least significant byte first. Bits 7:0 of word 14 are the low byte, and bits 31:24 of word 15 are the high byte.
- R5: Padding is always added. A message of L bytes yields floor((L+8)/64)+1 blocks. So 55 bytes give one block, and 56 bytes give two.
- R6: If the 0x80 byte lands at block offset 56 or later, the rest of that block is zero-filled. A further block follows that holds only zeros and the length.
- R7: `out_block_end` is 1 exactly on every sixteenth word of the output stream, counted from reset.
- R8: `out_first` is 1 on all sixteen words of a message's first block and 0 on every other word.
- R9: `out_final` is 1 only on the last word of a message's last block, and it is 1 there together with `out_block_end`.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_word` and its strobes hold steady. No word is dropped or repeated under any pattern of `out_ready`.
- R11: From the transfer of the last message byte until the last word of that message is loaded into the output register, `in_ready` is 0.
- R12: Back-to-back messages are handled independently. The bit-length count restarts at zero for each message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Unit takes the byte at this edge |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | This byte ends the message |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the word at this edge |
| out_word | output | 32 | Padded message word, little-endian byte packing |
| out_block_end | output | 1 | Word is the sixteenth of its block |
| out_first | output | 1 | Word belongs to the message's first block |
| out_final | output | 1 | Word closes the message's last block |

## Verification
The embedded properties rest on a few assumptions about the input side:
- `in_valid` is low while reset is held.
- Every message has at least one byte, and its end is marked by `in_last` on a transferred byte.
- The consumer may drop `out_ready` at any time.

The bench keeps within these limits. It holds the input idle during both resets. It drives only messages of one byte or more and raises `in_last` only together with `in_valid` on the final byte. It varies `out_ready` between always ready, a pseudo-random pattern, and a long stall on the first word.

// File: rtl/md5_pad_pkg.sv
package md5_pad_pkg;
  // Which kind of byte the sequencer emits at the current block offset
  typedef enum logic [1:0] {
    PH_DATA = 2'd0,  // copying message bytes
    PH_MARK = 2'd1,  // emitting the 0x80 byte
    PH_FILL = 2'd2,  // emitting zero bytes
    PH_LEN  = 2'd3   // emitting bit-length bytes
  } pad_phase_e;

  localparam logic [7:0] MARK_BYTE = 8'h80;
endpackage

// File: rtl/md5_pad_bitlen.sv
module md5_pad_bitlen #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             take_last,
  output logic [LEN_W-1:0] len_bits
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BYTE_W);

  logic [LEN_W-1:0] run_q;

  // Running count of bits; the total is latched on the closing byte,
  // and the running count restarts for the next message (R12)
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= '0;
      len_bits <= '0;
    end else if (take) begin
      if (take_last) begin
        len_bits <= run_q + STEP;
        run_q    <= '0;
      end else begin
        run_q    <= run_q + STEP;
      end
    end
  end
endmodule

// File: rtl/md5_pad_seq.sv
module md5_pad_seq
  import md5_pad_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BLK_BYTES  = 64,
  parameter int LEN_BYTES  = 8,
  localparam int LEN_W     = LEN_BYTES * BYTE_W,
  localparam int POS_W     = $clog2(BLK_BYTES),
  localparam int SUB_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              sink_free,
  input  logic [LEN_W-1:0]  len_bits,
  output logic [BYTE_W-1:0] byte_val,
  output logic              byte_step,
  output logic [SUB_W-1:0]  byte_lane,
  output logic              byte_blk_end,
  output logic              byte_first,
  output logic              byte_final
);
  localparam int LB_W      = $clog2(LEN_BYTES);
  localparam int LEN_START = BLK_BYTES - LEN_BYTES;
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(BLK_BYTES - 1);
  localparam logic [POS_W-1:0] LEN_POS   = POS_W'(LEN_START);
  localparam logic [SUB_W-1:0] LAST_LANE = SUB_W'(WORD_BYTES - 1);

  pad_phase_e       phase_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic             first_q;
  logic             word_end;
  logic             adv_ok;
  logic [BYTE_W-1:0] len_lane [LEN_BYTES];
  logic [LB_W-1:0]  len_idx;

  // Split the latched length into bytes, one lane per byte
  for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len_lane
    assign len_lane[g] = len_bits[g*BYTE_W +: BYTE_W];
  end

  assign pos_nxt  = pos_q + 1'b1;
  assign word_end = (pos_q[SUB_W-1:0] == LAST_LANE);
  // A byte that completes a word needs space in the output register
  assign adv_ok   = !word_end || sink_free;
  assign in_ready = (phase_q == PH_DATA) && adv_ok;
  assign byte_step = (phase_q == PH_DATA) ? (in_valid && in_ready) : adv_ok;
  // The length zone starts on a multiple of LEN_BYTES, so the low bits index it
  assign len_idx  = pos_q[LB_W-1:0];

  always_comb begin
    unique case (phase_q)
      PH_DATA: byte_val = in_data;
      PH_MARK: byte_val = MARK_BYTE;
      PH_FILL: byte_val = '0;
      PH_LEN:  byte_val = len_lane[len_idx];
      default: byte_val = '0;
    endcase
  end

  assign byte_lane    = pos_q[SUB_W-1:0];
  assign byte_blk_end = (pos_q == LAST_POS);
  assign byte_first   = first_q;
  assign byte_final   = (phase_q == PH_LEN) && (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_DATA;
      pos_q   <= '0;
      first_q <= 1'b1;
    end else if (byte_step) begin
      pos_q <= pos_nxt;
      if (phase_q == PH_LEN && pos_q == LAST_POS) begin
        first_q <= 1'b1;
      end else if (pos_q == LAST_POS) begin
        first_q <= 1'b0;
      end
      unique case (phase_q)
        PH_DATA: if (in_last) phase_q <= PH_MARK;
        PH_MARK: phase_q <= (pos_nxt == LEN_POS) ? PH_LEN : PH_FILL;
        PH_FILL: if (pos_nxt == LEN_POS) phase_q <= PH_LEN;
        PH_LEN:  if (pos_q == LAST_POS) phase_q <= PH_DATA;
        default: phase_q <= PH_DATA;
      endcase
    end
  end

  // R11: once the closing byte is taken, input stays blocked
  assert_no_input_in_pad_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid && in_ready && in_last)) |-> !in_ready);

  // R4: length bytes are only emitted in the last LEN_BYTES offsets
  assert_len_zone_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LEN) |-> (pos_q >= LEN_POS));
endmodule

// File: rtl/md5_pad_pack.sv
module md5_pad_pack #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BLK_BYTES  = 64,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int SUB_W     = $clog2(WORD_BYTES),
  localparam int WPB       = BLK_BYTES / WORD_BYTES,
  localparam int WC_W      = $clog2(WPB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              byte_step,
  input  logic [SUB_W-1:0]  byte_lane,
  input  logic              byte_blk_end,
  input  logic              byte_first,
  input  logic              byte_final,
  output logic              sink_free,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_block_end,
  output logic              out_first,
  output logic              out_final
);
  localparam logic [SUB_W-1:0] LAST_LANE = SUB_W'(WORD_BYTES - 1);

  logic [BYTE_W-1:0] lane_q [WORD_BYTES-1];
  logic              load;

  assign sink_free = !out_valid || out_ready;
  assign load      = byte_step && (byte_lane == LAST_LANE);

  // Lower lanes collect bytes; the top lane goes straight to the output
  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[g] <= '0;
      end else if (byte_step && byte_lane == SUB_W'(g)) begin
        lane_q[g] <= byte_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_block_end <= 1'b0;
      out_first     <= 1'b0;
      out_final     <= 1'b0;
    end else if (load) begin
      out_valid     <= 1'b1;
      for (int k = 0; k < WORD_BYTES - 1; k++) begin
        out_word[k*BYTE_W +: BYTE_W] <= lane_q[k];
      end
      out_word[WORD_W-1 -: BYTE_W] <= byte_val;
      out_block_end <= byte_blk_end;
      out_first     <= byte_first;
      out_final     <= byte_final;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Checker state: words handed over since reset, modulo one block
  logic [WC_W-1:0] chk_wcnt;
  always_ff @(posedge clk) begin
    if (rst) chk_wcnt <= '0;
    else if (out_valid && out_ready) chk_wcnt <= chk_wcnt + 1'b1;
  end

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
      $stable(out_block_end) && $stable(out_first) && $stable(out_final)));

  assert_block_end_place_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_block_end == (chk_wcnt == WC_W'(WPB - 1))));

  assert_final_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_final) |-> out_block_end);
endmodule

// File: rtl/md5_pad_unit.sv
module md5_pad_unit #(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BLK_BYTES  = 64,
  parameter int LEN_BYTES  = 8,
  localparam int WORD_W    = WORD_BYTES * BYTE_W,
  localparam int LEN_W     = LEN_BYTES * BYTE_W,
  localparam int SUB_W     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_block_end,
  output logic              out_first,
  output logic              out_final
);
  logic [LEN_W-1:0]  len_bits;
  logic              sink_free;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_step;
  logic [SUB_W-1:0]  byte_lane;
  logic              byte_blk_end;
  logic              byte_first;
  logic              byte_final;

  md5_pad_bitlen #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) bitlen_i (
    .clk       (clk),
    .rst       (rst),
    .take      (in_valid && in_ready),
    .take_last (in_last),
    .len_bits  (len_bits)
  );

  md5_pad_seq #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES),
    .BLK_BYTES(BLK_BYTES), .LEN_BYTES(LEN_BYTES)
  ) seq_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .sink_free    (sink_free),
    .len_bits     (len_bits),
    .byte_val     (byte_val),
    .byte_step    (byte_step),
    .byte_lane    (byte_lane),
    .byte_blk_end (byte_blk_end),
    .byte_first   (byte_first),
    .byte_final   (byte_final)
  );

  md5_pad_pack #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .BLK_BYTES(BLK_BYTES)
  ) pack_i (
    .clk           (clk),
    .rst           (rst),
    .byte_val      (byte_val),
    .byte_step     (byte_step),
    .byte_lane     (byte_lane),
    .byte_blk_end  (byte_blk_end),
    .byte_first    (byte_first),
    .byte_final    (byte_final),
    .sink_free     (sink_free),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_word      (out_word),
    .out_block_end (out_block_end),
    .out_first     (out_first),
    .out_final     (out_final)
  );
endmodule

// File: tb/md5_pad_unit_tb.sv
module md5_pad_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_block_end;
  logic        out_first;
  logic        out_final;

  int checks = 0;
  int fails  = 0;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;  // 50 MHz

  md5_pad_unit dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_block_end(out_block_end), .out_first(out_first), .out_final(out_final)
  );

  // Columns: message length in bytes, data seed, expected blocks, ready mode
  // (0 always ready, 1 pseudo-random, 2 long stall on first word)
  localparam int NVEC = 12;
  localparam int TAB [NVEC][4] = '{
    '{1,   8'h11, 1, 0},
    '{3,   8'h22, 1, 1},
    '{55,  8'h33, 1, 0},
    '{56,  8'h44, 2, 0},
    '{57,  8'h55, 2, 1},
    '{63,  8'h66, 2, 0},
    '{64,  8'h77, 2, 1},
    '{65,  8'h88, 2, 2},
    '{119, 8'h99, 2, 0},
    '{120, 8'hAA, 3, 1},
    '{128, 8'hBB, 3, 2},
    '{7,   8'hCC, 1, 1}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] msg_byte(input int seed, input int i);
    return 8'((seed + i * 37 + (i >> 3)) & 255);
  endfunction

  // Expected padded byte k of a message, built from R2 to R6
  function automatic logic [7:0] pad_byte(input int len, input int seed,
                                          input int k, input int total);
    logic [63:0] bits;
    bits = 64'(len) * 64'd8;
    if (k < len) return msg_byte(seed, k);
    if (k == len) return 8'h80;
    if (k >= total - 8) return bits[(k - (total - 8)) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic run_msg(input int len, input int seed, input int nblk, input int mode);
    int idx = 0;
    int wc = 0;
    int cyc = 0;
    int total = nblk * 16;
    int stall = 0;
    logic [31:0] held = '0;
    bit stall_bad = 0;
    bit pad_rdy = 0;
    logic [31:0] gw [256];
    bit gbe [256];
    bit gfi [256];
    bit gfn [256];
    bit data_ok = 1;
    bit be_ok = 1;
    bit fi_ok = 1;
    bit fn_ok = 1;
    logic [31:0] bad_act = '0;
    logic [31:0] bad_exp = '0;
    while (wc < total && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (mode)
        1: out_ready = lfsr[0] | lfsr[3];
        2: out_ready = !(stall < 8 && out_valid);
        default: out_ready = 1'b1;
      endcase
      if (idx < len) begin
        in_valid = 1'b1;
        in_data  = msg_byte(seed, idx);
        in_last  = (idx == len - 1);
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      #1;
      if (mode == 2 && out_valid && !out_ready) begin
        if (stall == 0) held = out_word;
        else if (out_word != held) stall_bad = 1;
        stall++;
      end
      if (idx == len && in_ready && !(out_valid && out_final)) pad_rdy = 1;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        gw[wc] = out_word; gbe[wc] = out_block_end;
        gfi[wc] = out_first; gfn[wc] = out_final;
        wc++;
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    chk(wc == total, "R5", $sformatf("word count len=%0d", len), 64'(wc), 64'(total));
    for (int w = 0; w < wc; w++) begin
      logic [31:0] e;
      for (int b = 0; b < 4; b++) e[b*8 +: 8] = pad_byte(len, seed, w*4 + b, total*4);
      if (gw[w] != e && data_ok) begin
        data_ok = 0; bad_act = gw[w]; bad_exp = e;
      end
      if (gbe[w] != ((w % 16) == 15)) be_ok = 0;
      if (gfi[w] != (w < 16)) fi_ok = 0;
      if (gfn[w] != (w == total - 1)) fn_ok = 0;
    end
    // R2 packing, R3 marker and fill, R4 length field, R6 extra block
    chk(data_ok, "R2/R3/R4/R6", $sformatf("padded data len=%0d", len), 64'(bad_act), 64'(bad_exp));
    chk(be_ok, "R7", $sformatf("block end placement len=%0d", len), 64'(be_ok), 64'd1);
    chk(fi_ok, "R8", $sformatf("first-block strobe len=%0d", len), 64'(fi_ok), 64'd1);
    chk(fn_ok, "R9", $sformatf("final strobe len=%0d", len), 64'(fn_ok), 64'd1);
    chk(!pad_rdy, "R11", $sformatf("in_ready during padding len=%0d", len), 64'(pad_rdy), 64'd0);
    if (mode == 2)
      chk(!stall_bad && stall >= 8, "R10", "word stable under stall", 64'(stall), 64'd8);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(!out_valid, "R10", $sformatf("no extra word len=%0d", len), 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

    // Table walk; consecutive messages also cover R12
    for (int v = 0; v < NVEC; v++) begin
      run_msg(TAB[v][0], TAB[v][1], TAB[v][2], TAB[v][3]);
    end

    // Reset in the middle of a message (R1), then a clean message (R12)
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 9; i++) begin
      in_valid = 1'b1; in_data = 8'(i); in_last = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R1", "out_valid after mid-message reset", 64'(out_valid), 64'd0);
    chk(in_ready, "R1", "in_ready after mid-message reset", 64'(in_ready), 64'd1);
    run_msg(20, 8'h5A, 1, 0);
    chk(1'b1, "R12", "fresh length after reset covered above", 64'd1, 64'd1);
    run_msg(60, 8'h3C, 2, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule